// File: doc/BRIEF.md
# Flash High-Voltage Enable Protection Gate

This block decides whether the high-voltage enable of an on-chip flash may be switched on for a program or erase step. It keeps an 8-bit protect code, loaded from non-volatile storage while reset is held. From that code it forms a 16-bit boundary: the code fills address bits [13:6], the two top bits are ones and the six low bits are zeros. Every address from that boundary up to 0xFFFF counts as locked. A request to raise the enable is granted only if the program or erase mode is properly set up, the protect code has been read back since the mode was set, and the operation does not touch locked space.

Software sets exactly one of the program or erase mode bits. It optionally selects a whole-array erase and presents the target address. It then reads the protect code, signalled here by a one-cycle read strobe, and finally writes the enable. A refused enable write leaves the enable low and raises a sticky violation flag. A test-voltage bypass input lifts every lock. The code 0xFF locks nothing. Any code other than 0xFF forbids whole-array erase.

Top module: `flash_hv_gate`

## Requirements
- R1: The boundary output equals {2'b11, code, 6'b000000}. The code is copied from `nv_prot_i` on every clock while `rst` is high and is held once reset ends, so later changes of `nv_prot_i` have no effect.
- R2: After a clock with `rst` high, `hven_o` and `viol_o` are 0.
- R3: With code 0xFF, no address is locked. A correctly sequenced program or erase at any address, 0xFFC0..0xFFFF included, is granted.
- R4: With a code other than 0xFF, a target address at or above the boundary is locked. An enable write for it is refused: `hven_o` stays 0 and `viol_o` becomes 1 on the next clock. An address below the boundary is granted, with `hven_o` high on the next clock.
- R5: Code 0x00 gives boundary 0xC000, and every address from 0xC000 to 0xFFFF is locked.
- R6: The protect code byte at address 0xFF7E is locked for every code except 0xFF and 0xFE.
- R7: While `mass_i` is 1, an enable write is refused whenever the code is not 0xFF, whatever the target address. With code 0xFF it is granted.
- R8: While `bypass_i` is 1, neither the address lock nor the whole-array lockout refuses an enable write.
- R9: An enable write is refused unless `prot_rd_i` was pulsed in an earlier cycle while exactly one of `pgm_i` and `erase_i` was 1, with that condition held since. A read made before the mode bit was set does not count.
- R10: An enable write is refused when both or neither of `pgm_i` and `erase_i` are 1. If that condition arises while `hven_o` is 1, `hven_o` drops on the next clock.
- R11: `viol_o` stays 1 until a cycle with `viol_clr_i` high and no new refusal. A refusal in the same cycle as a clear leaves it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the protect code |
| nv_prot_i | input | 8 | Non-volatile protect code value |
| tgt_addr_i | input | 16 | Target address of the program or erase |
| pgm_i | input | 1 | Program mode bit |
| erase_i | input | 1 | Erase mode bit |
| mass_i | input | 1 | Whole-array erase select |
| prot_rd_i | input | 1 | One-cycle strobe: protect code was read |
| hven_wr_i | input | 1 | One-cycle strobe: request to set the high-voltage enable |
| bypass_i | input | 1 | Test-voltage bypass of all protection |
| viol_clr_i | input | 1 | Write-one-to-clear of the violation flag |
| prot_start_o | output | 16 | Boundary address formed from the code |
| hven_o | output | 1 | High-voltage enable |
| viol_o | output | 1 | Sticky violation flag |

## Verification
The read strobe arms the gate on its clock edge. An enable write strobe in a later cycle sets `hven_o` or `viol_o` on the edge that samples it, so both results are due one clock after the write. The bench drives inputs on falling edges and samples both flags on the falling edge after that one clock. A mode drop clears the enable on the next edge and is sampled one falling edge later. The boundary output is checked a cycle after reset release and again after `nv_prot_i` changes.

// File: rtl/flash_gate_pkg.sv
package flash_gate_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_PGM   = 2'b01,
    OP_ERASE = 2'b10,
    OP_BAD   = 2'b11
  } op_e;

  function automatic op_e decode_op(input logic pgm, input logic erase);
    return op_e'({erase, pgm});
  endfunction

  function automatic logic op_valid(input op_e op);
    return (op == OP_PGM) || (op == OP_ERASE);
  endfunction

endpackage

// File: rtl/flash_prot_map.sv
module flash_prot_map #(
  parameter int ADDR_W = 16,
  parameter int PROT_W = 8,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PROT_W-1:0] nv_prot_i,
  input  logic [ADDR_W-1:0] tgt_addr_i,
  output logic [ADDR_W-1:0] start_o,
  output logic              open_o,
  output logic              hit_o
);
  localparam int HI_W = ADDR_W - PROT_W - PAGE_W;

  logic [PROT_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst) code_q <= nv_prot_i;
  end

  assign start_o = {{HI_W{1'b1}}, code_q, {PAGE_W{1'b0}}};
  assign open_o  = &code_q;
  assign hit_o   = !open_o && (tgt_addr_i >= start_o);
endmodule

// File: rtl/flash_seq_arm.sv
module flash_seq_arm
  import flash_gate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  op_e  op_i,
  input  logic prot_rd_i,
  output logic armed_o
);
  always_ff @(posedge clk) begin
    if (rst)                 armed_o <= 1'b0;
    else if (!op_valid(op_i)) armed_o <= 1'b0;
    else if (prot_rd_i)       armed_o <= 1'b1;
  end
endmodule

// File: rtl/flash_hv_ctrl.sv
module flash_hv_ctrl
  import flash_gate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  op_e  op_i,
  input  logic armed_i,
  input  logic hit_i,
  input  logic open_i,
  input  logic mass_i,
  input  logic bypass_i,
  input  logic hven_wr_i,
  input  logic viol_clr_i,
  output logic hven_o,
  output logic viol_o
);
  logic blocked, grant, refuse;

  always_comb begin
    blocked = !bypass_i && (mass_i ? !open_i : hit_i);
    grant   = hven_wr_i && !hven_o && armed_i && op_valid(op_i) && !blocked;
    refuse  = hven_wr_i && !hven_o && !grant;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hven_o <= 1'b0;
      viol_o <= 1'b0;
    end else begin
      if (!op_valid(op_i)) hven_o <= 1'b0;
      else if (grant)      hven_o <= 1'b1;
      if (refuse)          viol_o <= 1'b1;
      else if (viol_clr_i) viol_o <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_hv_gate.sv
module flash_hv_gate
  import flash_gate_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PROT_W = 8,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PROT_W-1:0] nv_prot_i,
  input  logic [ADDR_W-1:0] tgt_addr_i,
  input  logic              pgm_i,
  input  logic              erase_i,
  input  logic              mass_i,
  input  logic              prot_rd_i,
  input  logic              hven_wr_i,
  input  logic              bypass_i,
  input  logic              viol_clr_i,
  output logic [ADDR_W-1:0] prot_start_o,
  output logic              hven_o,
  output logic              viol_o
);
  op_e  op;
  logic armed, hit, open_code;

  assign op = decode_op(pgm_i, erase_i);

  flash_prot_map #(.ADDR_W(ADDR_W), .PROT_W(PROT_W), .PAGE_W(PAGE_W)) map_i (
    .clk(clk), .rst(rst), .nv_prot_i(nv_prot_i), .tgt_addr_i(tgt_addr_i),
    .start_o(prot_start_o), .open_o(open_code), .hit_o(hit)
  );

  flash_seq_arm arm_i (
    .clk(clk), .rst(rst), .op_i(op), .prot_rd_i(prot_rd_i), .armed_o(armed)
  );

  flash_hv_ctrl ctrl_i (
    .clk(clk), .rst(rst), .op_i(op), .armed_i(armed), .hit_i(hit),
    .open_i(open_code), .mass_i(mass_i), .bypass_i(bypass_i),
    .hven_wr_i(hven_wr_i), .viol_clr_i(viol_clr_i),
    .hven_o(hven_o), .viol_o(viol_o)
  );
endmodule

// File: rtl/flash_hv_gate_chk.sv
module flash_hv_gate_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] tgt_addr_i,
  input logic              pgm_i,
  input logic              erase_i,
  input logic              mass_i,
  input logic              hven_wr_i,
  input logic              bypass_i,
  input logic              viol_clr_i,
  input logic [ADDR_W-1:0] prot_start_o,
  input logic              hven_o,
  input logic              viol_o,
  input logic              armed
);
  localparam logic [ADDR_W-1:0] OPEN_START = {ADDR_W{1'b1}} << 6;

  a_r2_reset_clears: assert property (@(posedge clk)
    rst |=> (!hven_o && !viol_o));

  a_r10_mode_drop: assert property (@(posedge clk) disable iff (rst)
    !(pgm_i ^ erase_i) |=> !hven_o);

  a_r11_viol_sticky: assert property (@(posedge clk) disable iff (rst)
    (viol_o && !viol_clr_i) |=> viol_o);

  a_r7_mass_lock: assert property (@(posedge clk) disable iff (rst)
    (hven_wr_i && !hven_o && mass_i && !bypass_i && prot_start_o != OPEN_START)
      |=> (!hven_o && viol_o));

  a_r4_addr_lock: assert property (@(posedge clk) disable iff (rst)
    (hven_wr_i && !hven_o && !mass_i && !bypass_i && prot_start_o != OPEN_START
      && tgt_addr_i >= prot_start_o) |=> (!hven_o && viol_o));

  a_r9_armed_first: assert property (@(posedge clk) disable iff (rst)
    $rose(hven_o) |-> $past(armed));
endmodule

bind flash_hv_gate flash_hv_gate_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .tgt_addr_i(tgt_addr_i), .pgm_i(pgm_i),
  .erase_i(erase_i), .mass_i(mass_i), .hven_wr_i(hven_wr_i),
  .bypass_i(bypass_i), .viol_clr_i(viol_clr_i), .prot_start_o(prot_start_o),
  .hven_o(hven_o), .viol_o(viol_o), .armed(armed)
);

// File: tb/flash_hv_gate_tb_top.sv
module flash_hv_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  nv_prot_i = 8'hFF;
  logic [15:0] tgt_addr_i = '0;
  logic        pgm_i = 0, erase_i = 0, mass_i = 0, prot_rd_i = 0;
  logic        hven_wr_i = 0, bypass_i = 0, viol_clr_i = 0;
  logic [15:0] prot_start_o;
  logic        hven_o, viol_o;

  int total = 0;
  int bad = 0;
  logic [7:0] cur_code;

  always #4 clk = ~clk;

  flash_hv_gate dut_i (
    .clk(clk), .rst(rst), .nv_prot_i(nv_prot_i), .tgt_addr_i(tgt_addr_i),
    .pgm_i(pgm_i), .erase_i(erase_i), .mass_i(mass_i), .prot_rd_i(prot_rd_i),
    .hven_wr_i(hven_wr_i), .bypass_i(bypass_i), .viol_clr_i(viol_clr_i),
    .prot_start_o(prot_start_o), .hven_o(hven_o), .viol_o(viol_o)
  );

  function automatic logic [15:0] exp_start(input logic [7:0] c);
    return {2'b11, c, 6'b0};
  endfunction

  function automatic logic exp_grant(input logic [7:0] c, input logic [15:0] a,
      input logic p, input logic e, input logic m, input logic b, input logic rd);
    logic lock;
    if (!(p ^ e) || !rd) return 1'b0;
    if (b) return 1'b1;
    if (m) return c == 8'hFF;
    lock = (c != 8'hFF) && (a >= exp_start(c));
    return !lock;
  endfunction

  task automatic check(input logic ok, input string req, input logic [15:0] act,
      input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] c);
    @(negedge clk);
    rst = 1; nv_prot_i = c;
    repeat (3) @(negedge clk);
    rst = 0; cur_code = c;
    nv_prot_i = ~c;
    @(negedge clk);
  endtask

  task automatic attempt(input logic p, input logic e, input logic m,
      input logic [15:0] a, input logic b, input logic rd, input string req);
    logic g;
    g = exp_grant(cur_code, a, p, e, m, b, rd);
    @(negedge clk);
    pgm_i = p; erase_i = e; mass_i = m; tgt_addr_i = a; bypass_i = b;
    @(negedge clk);
    prot_rd_i = rd;
    @(negedge clk);
    prot_rd_i = 0; hven_wr_i = 1;
    @(negedge clk);
    hven_wr_i = 0;
    check(hven_o == g, req, {15'd0, hven_o}, {15'd0, g});
    check(viol_o == !g, req, {15'd0, viol_o}, {15'd0, !g});
    pgm_i = 0; erase_i = 0; mass_i = 0; bypass_i = 0; viol_clr_i = 1;
    @(negedge clk);
    viol_clr_i = 0;
    check(hven_o == 0, "R10 mode drop", {15'd0, hven_o}, 16'd0);
    check(viol_o == 0, "R11 clear", {15'd0, viol_o}, 16'd0);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] a;
    void'($urandom(32'd2024));
    do_reset(8'h12);
    check(hven_o == 0 && viol_o == 0, "R2", {14'd0, hven_o, viol_o}, 16'd0);
    check(prot_start_o == exp_start(8'h12), "R1", prot_start_o, exp_start(8'h12));
    repeat (2) @(negedge clk);
    check(prot_start_o == exp_start(8'h12), "R1 held", prot_start_o, exp_start(8'h12));

    attempt(1, 0, 0, exp_start(8'h12), 0, 1, "R4 at boundary");
    attempt(0, 1, 0, exp_start(8'h12) - 16'd1, 0, 1, "R4 below");
    attempt(1, 0, 0, 16'hFF7E, 0, 1, "R6 code 12");
    attempt(0, 1, 1, 16'h0000, 0, 1, "R7 mass locked");
    attempt(0, 1, 1, 16'hFFFF, 1, 1, "R8 bypass mass");
    attempt(1, 0, 0, 16'hFFFF, 1, 1, "R8 bypass addr");
    attempt(1, 0, 0, 16'h0100, 0, 0, "R9 no read");
    attempt(1, 1, 0, 16'h0100, 0, 1, "R10 both");
    attempt(0, 0, 0, 16'h0100, 0, 1, "R10 none");

    // R9: read before the mode bit is set does not arm
    @(negedge clk); tgt_addr_i = 16'h0100; prot_rd_i = 1;
    @(negedge clk); prot_rd_i = 0; pgm_i = 1;
    @(negedge clk); hven_wr_i = 1;
    @(negedge clk); hven_wr_i = 0;
    check(hven_o == 0 && viol_o == 1, "R9 early read", {14'd0, hven_o, viol_o}, 16'd1);
    // R11: sticky, and a refusal beats a clear
    repeat (3) @(negedge clk);
    check(viol_o == 1, "R11 sticky", {15'd0, viol_o}, 16'd1);
    hven_wr_i = 1; viol_clr_i = 1;
    @(negedge clk); hven_wr_i = 0; viol_clr_i = 0;
    check(viol_o == 1, "R11 set wins", {15'd0, viol_o}, 16'd1);
    pgm_i = 0; viol_clr_i = 1;
    @(negedge clk); viol_clr_i = 0;

    do_reset(8'h00);
    check(prot_start_o == 16'hC000, "R5 start", prot_start_o, 16'hC000);
    attempt(1, 0, 0, 16'hC000, 0, 1, "R5 lowest");
    attempt(0, 1, 0, 16'hBFFF, 0, 1, "R5 below");
    do_reset(8'hFE);
    attempt(1, 0, 0, 16'hFF7E, 0, 1, "R6 code FE");
    attempt(1, 0, 0, 16'hFF80, 0, 1, "R4 code FE");
    do_reset(8'hFD);
    attempt(1, 0, 0, 16'hFF7E, 0, 1, "R6 code FD");
    do_reset(8'hFF);
    attempt(1, 0, 0, 16'hFFFF, 0, 1, "R3 top");
    attempt(0, 1, 0, 16'hFFC0, 0, 1, "R3 page");
    attempt(0, 1, 1, 16'h1234, 0, 1, "R7 mass open");

    for (int k = 0; k < 200; k++) begin
      if (k % 25 == 0) begin
        do_reset(8'($urandom));
        check(prot_start_o == exp_start(cur_code), "R1 rand", prot_start_o,
              exp_start(cur_code));
      end
      a = 16'($urandom);
      if ($urandom % 2) a = exp_start(cur_code) + 16'($signed(4'($urandom)));
      attempt(1'($urandom), 1'($urandom), ($urandom % 5) == 0, a,
              ($urandom % 6) == 0, ($urandom % 8) != 0, "R4 R7 R8 R9 rand");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule